// File: doc/BRIEF.md
# Per-Channel Latched Fault Supervisor

This block watches a bank of low-side output channels and keeps two sticky fault flags for each one. A protection flag records an overload or over-temperature event that occurred while the channel was driven; once it is set, the channel's fault-off request is raised and held, so that the gate logic keeps the channel off. An open-load flag records that the output-low indication persisted while the channel was off and diagnosis was enabled. The inputs are per-channel comparator outputs, the requested gate state, per-channel standby and a common diagnosis-enable line. All delays are counted in system-clock ticks.

Each channel has its own state machine. Its states are: `CH_STBY` (standby, no diagnosis, flags cleared), `CH_IDLE` (off, monitoring), `CH_OL_WAIT` (off, counting the open-load window), `CH_ON` (driven, monitoring), `CH_OC_WAIT` (driven, counting the overload window) and `CH_TRIPPED` (protection fault latched, fault-off raised). The transitions are: standby asserted moves any state to `CH_STBY`; standby released moves `CH_STBY` to `CH_IDLE`. A gate request moves `CH_IDLE` or `CH_OL_WAIT` to `CH_ON`, and removing it moves `CH_ON` or `CH_OC_WAIT` to `CH_IDLE`. Overcurrent moves `CH_ON` to `CH_OC_WAIT`. Overcurrent dropping moves `CH_OC_WAIT` back to `CH_ON`. When the overload window completes, or an over-temperature is seen in `CH_ON` or `CH_OC_WAIT`, the channel goes to `CH_TRIPPED`. Output-low with diagnosis enabled moves `CH_IDLE` to `CH_OL_WAIT`. Losing either condition returns it to `CH_IDLE`, and a completed open-load window sets the open-load flag and also returns it to `CH_IDLE`.

Top module: `fault_latch_diag`

## Requirements
- R1: After reset all protection flags, open-load flags and fault-off requests are 0, and every channel is in standby.
- R2: While a channel is on, overcurrent sampled high on OVL_TICKS consecutive clock edges sets that channel's protection flag and fault-off request at the last of those edges. Counting starts at the first edge at which the channel is already on.
- R3: An overcurrent run shorter than OVL_TICKS edges sets no flag, and the next run counts from one again.
- R4: Over-temperature sampled high while the channel is on sets the protection flag and fault-off request at that same edge.
- R5: A tripped channel keeps fault-off at 1 whatever its gate request does, until standby is applied.
- R6: While the channel is off (gate request 0, not tripped, not in standby) and diagnosis is enabled, output-low sampled high on OL_TICKS consecutive edges sets the open-load flag. If output-low or diagnosis enable drops before then, the count restarts.
- R7: No open-load flag is set while the channel is on, in standby or tripped.
- R8: Both flags stay at 1 after the fault condition goes away, as long as standby is not applied.
- R9: Standby sampled high clears both flags and fault-off at that edge. This takes priority over a flag that would have been set at the same edge.
- R10: Overcurrent and over-temperature on a channel whose gate request is 0 have no effect.
- R11: Bit i of every per-channel vector belongs to channel i, and a fault on one channel leaves the others' outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_on | input | NCH | Requested gate state per channel |
| stby | input | NCH | Standby per channel; clears the flags |
| diag_en | input | 1 | Enables open-load diagnosis while off |
| oc_det | input | NCH | Overcurrent comparator per channel |
| ot_det | input | NCH | Over-temperature sensor per channel |
| out_low | input | NCH | Output-low level indication per channel |
| prot_flag | output | NCH | Latched protection flag |
| open_flag | output | NCH | Latched open-load flag |
| fault_off | output | NCH | Request to hold the channel off |

## Verification
The bench builds the block with OVL_TICKS = 4 and OL_TICKS = 6 instead of the default windows of tens of ticks. This makes it practical to count windows edge by edge. It can then show that a run one edge short leaves the flag clear and the next edge sets it, and it can test the restart after an interrupted run. The short windows also put the standby-versus-set race at the window's last edge within a few cycles of setup.

// File: rtl/fdiag_pkg.sv
package fdiag_pkg;

    typedef enum logic [2:0] {
        CH_STBY    = 3'd0,
        CH_IDLE    = 3'd1,
        CH_OL_WAIT = 3'd2,
        CH_ON      = 3'd3,
        CH_OC_WAIT = 3'd4,
        CH_TRIPPED = 3'd5
    } ch_state_t;

    function automatic int unsigned max_ticks(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fdiag_delay_ctr.sv
module fdiag_delay_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] limit_m1,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    assign done = (cnt_q == limit_m1);

    // window counter never passes the selected limit (R3, R6 restart logic)
    p_cnt_within_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit_m1);

endmodule

// File: rtl/fdiag_chan_fsm.sv
module fdiag_chan_fsm
    import fdiag_pkg::*;
#(
    parameter int CW        = 8,
    parameter int OVL_TICKS = 40,
    parameter int OL_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_on_i,
    input  logic stby_i,
    input  logic diag_en_i,
    input  logic oc_i,
    input  logic ot_i,
    input  logic out_low_i,
    output logic prot_o,
    output logic ol_o,
    output logic fault_off_o
);

    localparam logic [CW-1:0] OVL_M1 = CW'(OVL_TICKS - 1);
    localparam logic [CW-1:0] OL_M1  = CW'(OL_TICKS - 1);

    ch_state_t     state_q, state_d;
    logic          ol_q, ol_d;
    logic          cnt_run;
    logic          cnt_done;
    logic [CW-1:0] cnt_limit;
    logic          ol_cond;

    assign ol_cond   = diag_en_i && out_low_i;
    assign cnt_limit = (state_q == CH_OL_WAIT) ? OL_M1 : OVL_M1;

    fdiag_delay_ctr #(.CW(CW)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (cnt_run),
        .limit_m1 (cnt_limit),
        .done     (cnt_done)
    );

    // next state, counter control and open-load flag update
    always_comb begin
        state_d = state_q;
        cnt_run = 1'b0;
        ol_d    = ol_q;
        if (stby_i) begin
            state_d = CH_STBY;
            ol_d    = 1'b0;
        end else begin
            unique case (state_q)
                CH_STBY: begin
                    state_d = CH_IDLE;
                end
                CH_IDLE: begin
                    if (gate_on_i) begin
                        state_d = CH_ON;
                    end else if (ol_cond) begin
                        state_d = CH_OL_WAIT;
                        cnt_run = 1'b1;
                    end
                end
                CH_OL_WAIT: begin
                    if (gate_on_i) begin
                        state_d = CH_ON;
                    end else if (!ol_cond) begin
                        state_d = CH_IDLE;
                    end else if (cnt_done) begin
                        state_d = CH_IDLE;
                        ol_d    = 1'b1;
                    end else begin
                        cnt_run = 1'b1;
                    end
                end
                CH_ON: begin
                    if (!gate_on_i) begin
                        state_d = CH_IDLE;
                    end else if (ot_i) begin
                        state_d = CH_TRIPPED;
                    end else if (oc_i) begin
                        state_d = CH_OC_WAIT;
                        cnt_run = 1'b1;
                    end
                end
                CH_OC_WAIT: begin
                    if (!gate_on_i) begin
                        state_d = CH_IDLE;
                    end else if (ot_i) begin
                        state_d = CH_TRIPPED;
                    end else if (!oc_i) begin
                        state_d = CH_ON;
                    end else if (cnt_done) begin
                        state_d = CH_TRIPPED;
                    end else begin
                        cnt_run = 1'b1;
                    end
                end
                CH_TRIPPED: begin
                    state_d = CH_TRIPPED;
                end
                default: begin
                    state_d = CH_STBY;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STBY;
            ol_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ol_q    <= ol_d;
        end
    end

    // outputs
    always_comb begin
        prot_o      = (state_q == CH_TRIPPED);
        fault_off_o = (state_q == CH_TRIPPED);
        ol_o        = ol_q;
    end

    // protection flag only rises after a sampled gate request (R2, R4, R10)
    p_prot_needs_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_o) |-> $past(gate_on_i));

    // standby clears everything at the edge it is sampled (R9)
    p_stby_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stby_i) |-> (!prot_o && !ol_o && !fault_off_o));

    // protection flag is sticky without standby (R8)
    p_prot_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_o && !stby_i) |=> prot_o);

    // open-load flag is sticky without standby (R8)
    p_ol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_o && !stby_i) |=> ol_o);

    // open-load only rises from an off, diagnosed, output-low sample (R7)
    p_ol_only_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_o) |-> $past(!gate_on_i && diag_en_i && out_low_i && !prot_o));

    // tripped channel holds fault-off while gate toggles (R5)
    p_trip_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_off_o && !stby_i) |=> fault_off_o);

endmodule

// File: rtl/fault_latch_diag.sv
module fault_latch_diag
    import fdiag_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int OVL_TICKS = 40,
    parameter int OL_TICKS  = 100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] gate_on,
    input  logic [NCH-1:0] stby,
    input  logic           diag_en,
    input  logic [NCH-1:0] oc_det,
    input  logic [NCH-1:0] ot_det,
    input  logic [NCH-1:0] out_low,
    output logic [NCH-1:0] prot_flag,
    output logic [NCH-1:0] open_flag,
    output logic [NCH-1:0] fault_off
);

    localparam int MAXT = max_ticks(OVL_TICKS, OL_TICKS);
    localparam int CW   = $clog2(MAXT + 1);

    initial begin
        if (OVL_TICKS < 2 || OL_TICKS < 2) begin
            $error("fault_latch_diag: delay windows must be at least 2 ticks");
        end
    end

    for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
        fdiag_chan_fsm #(
            .CW        (CW),
            .OVL_TICKS (OVL_TICKS),
            .OL_TICKS  (OL_TICKS)
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .gate_on_i   (gate_on[gi]),
            .stby_i      (stby[gi]),
            .diag_en_i   (diag_en),
            .oc_i        (oc_det[gi]),
            .ot_i        (ot_det[gi]),
            .out_low_i   (out_low[gi]),
            .prot_o      (prot_flag[gi]),
            .ol_o        (open_flag[gi]),
            .fault_off_o (fault_off[gi])
        );
    end

endmodule

// File: tb/sim_fault_latch_diag.sv
`timescale 1ns/1ps
module sim_fault_latch_diag;

    localparam int NCH = 8;
    localparam int OVL = 4;
    localparam int OLT = 6;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [NCH-1:0] gate_on, stby, oc_det, ot_det, out_low;
    logic           diag_en;
    logic [NCH-1:0] prot_flag, open_flag, fault_off;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fault_latch_diag #(.NCH(NCH), .OVL_TICKS(OVL), .OL_TICKS(OLT)) u0 (
        .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .stby(stby),
        .diag_en(diag_en), .oc_det(oc_det), .ot_det(ot_det), .out_low(out_low),
        .prot_flag(prot_flag), .open_flag(open_flag), .fault_off(fault_off)
    );

    task automatic check(input string req, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 prot", prot_flag, '0);
        check("R1 open", open_flag, '0);
        check("R1 fault_off", fault_off, '0);
    endtask

    task automatic t_overload();
        gate_on[0] = 1'b1; step(1);
        oc_det[0] = 1'b1; step(OVL - 1);
        check("R3 short run", prot_flag, '0);
        oc_det[0] = 1'b0; step(1);
        oc_det[0] = 1'b1; step(OVL - 1);
        check("R3 restart", prot_flag, '0);
        step(1);
        check("R2 prot set", prot_flag, 8'b0000_0001);
        check("R2 fault_off", fault_off, 8'b0000_0001);
        oc_det[0] = 1'b0; step(5);
        check("R8 prot sticky", prot_flag, 8'b0000_0001);
        gate_on[0] = 1'b0; step(2);
        check("R5 gate low", fault_off, 8'b0000_0001);
        gate_on[0] = 1'b1; step(2);
        check("R5 gate high", fault_off, 8'b0000_0001);
        stby[0] = 1'b1; step(1);
        check("R9 clear prot", prot_flag, '0);
        check("R9 clear fault_off", fault_off, '0);
        stby[0] = 1'b0; step(2);
        check("R9 rearmed", fault_off, '0);
        gate_on[0] = 1'b0; step(1);
    endtask

    task automatic t_overtemp();
        gate_on[1] = 1'b1; step(1);
        ot_det[1] = 1'b1; step(1);
        check("R4 ot trip", prot_flag, 8'b0000_0010);
        check("R11 only ch1", fault_off, 8'b0000_0010);
        ot_det[1] = 1'b0;
        ot_det[2] = 1'b1; oc_det[2] = 1'b1; step(10);
        check("R10 off ignores", prot_flag, 8'b0000_0010);
        ot_det[2] = 1'b0; oc_det[2] = 1'b0;
        gate_on[1] = 1'b0; step(1);
    endtask

    task automatic t_openload();
        diag_en = 1'b1;
        out_low[3] = 1'b1; step(OLT - 1);
        check("R6 short", open_flag, '0);
        out_low[3] = 1'b0; step(1);
        out_low[3] = 1'b1; step(OLT - 1);
        check("R6 restart", open_flag, '0);
        step(1);
        check("R6 set", open_flag, 8'b0000_1000);
        out_low[3] = 1'b0; step(3);
        check("R8 open sticky", open_flag, 8'b0000_1000);
        out_low[4] = 1'b1; step(3);
        diag_en = 1'b0; step(1);
        diag_en = 1'b1; step(OLT - 1);
        check("R6 diag drop restart", open_flag, 8'b0000_1000);
        step(1);
        check("R6 ch4 set", open_flag, 8'b0001_1000);
        out_low[4] = 1'b0;
    endtask

    task automatic t_ol_ignored();
        gate_on[5] = 1'b1; step(1);
        stby[6] = 1'b1;
        out_low[5] = 1'b1; out_low[6] = 1'b1; out_low[1] = 1'b1;
        step(3 * OLT);
        check("R7 on/stby/tripped", open_flag, 8'b0001_1000);
        out_low[5] = 1'b0; out_low[6] = 1'b0; out_low[1] = 1'b0;
        stby[6] = 1'b0; gate_on[5] = 1'b0; step(1);
    endtask

    task automatic t_priority();
        gate_on[7] = 1'b1; step(1);
        oc_det[7] = 1'b1; step(OVL - 1);
        stby[7] = 1'b1; step(1);
        check("R9 prio prot", prot_flag, 8'b0000_0010);
        stby[7] = 1'b0; oc_det[7] = 1'b0; gate_on[7] = 1'b0; step(2);
        check("R9 stays clear", prot_flag, 8'b0000_0010);
        out_low[5] = 1'b1; step(OLT - 1);
        stby[5] = 1'b1; step(1);
        check("R9 prio open", open_flag, 8'b0001_1000);
        out_low[5] = 1'b0; stby[5] = 1'b0;
        stby[3] = 1'b1; stby[1] = 1'b1; step(1);
        check("R9 clear open", open_flag, 8'b0001_0000);
        check("R9 clear ch1", prot_flag, '0);
        stby[3] = 1'b0; stby[1] = 1'b0; step(1);
    endtask

    initial begin
        rst_n = 1'b0;
        gate_on = '0; stby = '1; oc_det = '0; ot_det = '0; out_low = '0; diag_en = 1'b0;
        step(3);
        t_reset();
        rst_n = 1'b1;
        stby = '0;
        step(1);
        t_reset();
        t_overload();
        t_overtemp();
        t_openload();
        t_ol_ignored();
        t_priority();
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule